// File: doc/BRIEF.md
# Ready/valid link protocol monitor

This block sits beside one ready/valid stream link and does not drive it. It watches the valid, ready, payload and frame-marker (first/last) wires, and it records breaches of the handshake rules in a set of sticky error bits. A beat moves only in a cycle where valid and ready are both high. Until that cycle, an upstream endpoint that declares itself well behaved must keep valid asserted and keep the payload steady.

Four static configuration bits describe the two endpoints. The first says the upstream holds its payload steady. The second says the downstream depends on that. The third says the downstream samples only under valid. The fourth says the upstream depends on that. The monitor flags the pairing as illegal unless (holds-steady or not depends-on-steady) and (respects-valid or not depends-on-respect) holds. The per-beat rule checks apply only when the upstream declares that it holds its payload steady. With every flag clear, the monitor is fully permissive.

Top module: `stream_hs_monitor`

## Requirements
- R1: While rst_ni is low, and after its release until a breach is recorded, err_bits_o is 3'b000 and err_o is low.
- R2: An accepted beat (valid_i and ready_i high in the same cycle) ends the pending state. A drop of valid or a payload change in the following cycle records no error.
- R3: With up_holds_i high, a cycle where valid_i is low after a cycle where valid_i was high and ready_i low sets err_bits_o[1] (valid retraction) at the next clock edge.
- R4: With up_holds_i high, a cycle where valid_i is high after an unaccepted valid cycle sets err_bits_o[2] (payload stability) at the next clock edge if data_i, first_i or last_i differs from the previous cycle.
- R5: ready_i may toggle freely while valid_i is low; this alone never sets any error bit.
- R6: With up_holds_i low, err_bits_o[1] and err_bits_o[2] never set, whatever the traffic.
- R7: If (up_holds_i | ~dn_needs_hold_i) & (dn_gates_i | ~up_needs_gate_i) is false, err_bits_o[0] (configuration) sets at the first clock edge after reset release. Otherwise err_bits_o[0] never sets.
- R8: Error bits stay set until rst_ni is asserted, and err_o is the OR of err_bits_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Link valid |
| ready_i | input | 1 | Link ready |
| data_i | input | DATA_W | Link payload |
| first_i | input | 1 | Frame start marker |
| last_i | input | 1 | Frame end marker |
| up_holds_i | input | 1 | Upstream keeps payload steady until acceptance |
| dn_needs_hold_i | input | 1 | Downstream depends on payload being steady |
| dn_gates_i | input | 1 | Downstream samples payload only under valid |
| up_needs_gate_i | input | 1 | Upstream depends on downstream respecting valid |
| err_o | output | 1 | Any error recorded |
| err_bits_o | output | 3 | Sticky errors: [0] configuration, [1] valid retraction, [2] payload stability |

## Verification
The bench targets the cycle right after acceptance. A monitor that kept the beat pending there would flag a legal valid drop or payload change. It also targets a change on only first_i or last_i, which a monitor that compared data alone would miss. Idle cycles where ready toggles must stay clean, or a monitor keyed on ready would misfire. Each configuration combination is swept, so an inverted term in the compatibility check, or a stability check left on when the upstream makes no promise, shows up as a spurious or missing bit.

// File: rtl/stream_hs_pkg.sv
package stream_hs_pkg;
  localparam int ERR_N    = 3;
  localparam int ERR_CFG  = 0;
  localparam int ERR_RET  = 1;
  localparam int ERR_STAB = 2;
endpackage

// File: rtl/shm_beat_track.sv
module shm_beat_track #(
  parameter int W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic         ready_i,
  input  logic [W-1:0] beat_i,
  output logic         pend_o,
  output logic [W-1:0] snap_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      snap_o <= '0;
    end else begin
      pend_o <= valid_i & ~ready_i;
      snap_o <= beat_i;
    end
  end
endmodule

// File: rtl/shm_rule_eval.sv
module shm_rule_eval #(
  parameter int W = 18
) (
  input  logic                          pend_i,
  input  logic [W-1:0]                  snap_i,
  input  logic                          valid_i,
  input  logic [W-1:0]                  beat_i,
  input  logic                          up_holds_i,
  input  logic                          dn_needs_hold_i,
  input  logic                          dn_gates_i,
  input  logic                          up_needs_gate_i,
  output logic [stream_hs_pkg::ERR_N-1:0] viol_o
);
  import stream_hs_pkg::*;
  logic compat;
  always_comb begin
    compat            = (up_holds_i | ~dn_needs_hold_i) & (dn_gates_i | ~up_needs_gate_i);
    viol_o            = '0;
    viol_o[ERR_CFG]   = ~compat;
    viol_o[ERR_RET]   = up_holds_i & pend_i & ~valid_i;
    viol_o[ERR_STAB]  = up_holds_i & pend_i & valid_i & (beat_i != snap_i);
  end
endmodule

// File: rtl/shm_sticky_errs.sv
module shm_sticky_errs #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o[g] <= 1'b0;
      else if (set_i[g]) q_o[g] <= 1'b1;
    end
    a_r8_sticky_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      q_o[g] |=> q_o[g]);
  end
endmodule

// File: rtl/stream_hs_monitor.sv
module stream_hs_monitor #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              ready_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              first_i,
  input  logic              last_i,
  input  logic              up_holds_i,
  input  logic              dn_needs_hold_i,
  input  logic              dn_gates_i,
  input  logic              up_needs_gate_i,
  output logic              err_o,
  output logic [2:0]        err_bits_o
);
  import stream_hs_pkg::*;
  localparam int BEAT_W = DATA_W + 2;

  logic [BEAT_W-1:0] beat, snap;
  logic              pend;
  logic [ERR_N-1:0]  viol, errs;

  assign beat = {first_i, last_i, data_i};

  shm_beat_track #(.W(BEAT_W)) u_track (
    .clk_i, .rst_ni, .valid_i, .ready_i,
    .beat_i(beat), .pend_o(pend), .snap_o(snap)
  );

  shm_rule_eval #(.W(BEAT_W)) u_rules (
    .pend_i(pend), .snap_i(snap), .valid_i, .beat_i(beat),
    .up_holds_i, .dn_needs_hold_i, .dn_gates_i, .up_needs_gate_i,
    .viol_o(viol)
  );

  shm_sticky_errs #(.N(ERR_N)) u_errs (
    .clk_i, .rst_ni, .set_i(viol), .q_o(errs)
  );

  assign err_bits_o = errs;
  assign err_o      = |errs;

  a_r3_retract_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_holds_i && valid_i && !ready_i) ##1 (!valid_i) |=> err_bits_o[ERR_RET]);
  a_r4_stab_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_holds_i && pend && valid_i && beat != snap) |=> err_bits_o[ERR_STAB]);
  a_r5_idle_ready_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend && !valid_i) |=> $stable(err_bits_o[ERR_STAB:ERR_RET]));
  a_r6_no_rule_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!up_holds_i) |=> !$rose(err_bits_o[ERR_RET]) && !$rose(err_bits_o[ERR_STAB]));
  a_r7_cfg_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((up_holds_i | ~dn_needs_hold_i) & (dn_gates_i | ~up_needs_gate_i)) |=> err_bits_o[ERR_CFG]);
  a_r8_any: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (err_bits_o != 3'b000));
endmodule

// File: tb/sim_stream_hs_monitor.sv
`timescale 1ns/1ps
module sim_stream_hs_monitor;
  localparam int DW = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic v = 0, r = 0, f = 0, l = 0;
  logic [DW-1:0] d = '0;
  logic ca = 0, cb = 0, cc = 0, cd = 0;
  logic eo;
  logic [2:0] eb;
  int vectors = 0, fails = 0;
  bit done = 0;

  // behavioural reference
  bit m_pend;
  logic [DW+1:0] m_snap;
  logic [2:0] m_err;

  always #5 clk = ~clk;

  stream_hs_monitor #(.DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(v), .ready_i(r), .data_i(d),
    .first_i(f), .last_i(l), .up_holds_i(ca), .dn_needs_hold_i(cb),
    .dn_gates_i(cc), .up_needs_gate_i(cd), .err_o(eo), .err_bits_o(eb));

  task automatic check(string tag);
    vectors++;
    if (eb !== m_err || eo !== (|m_err)) begin
      fails++;
      $display("FAIL %s: err_bits=%b err=%b expected bits=%b err=%b", tag, eb, eo, m_err, |m_err);
    end
  endtask

  task automatic cyc(bit vi, bit ri, logic [DW-1:0] di, bit fi, bit li, string tag);
    v = vi; r = ri; d = di; f = fi; l = li;
    @(posedge clk);
    if (rst_n) begin
      if (!((ca || !cb) && (cc || !cd))) m_err[0] = 1;
      if (ca && m_pend && !vi) m_err[1] = 1;
      if (ca && m_pend && vi && ({fi, li, di} != m_snap)) m_err[2] = 1;
      m_pend = vi && !ri;
      m_snap = {fi, li, di};
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic restart(bit a, bit b, bit c, bit dd);
    @(negedge clk);
    rst_n = 0; v = 0; r = 0;
    ca = a; cb = b; cc = c; cd = dd;
    m_pend = 0; m_snap = '0; m_err = '0;
    #1 check("R1");
    @(negedge clk);
    check("R1");
    rst_n = 1;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: timeout, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    m_pend = 0; m_snap = '0; m_err = '0;
    repeat (2) @(negedge clk);
    // R6: permissive config, chaotic traffic
    restart(0, 0, 0, 0);
    cyc(0, 0, 16'h0, 0, 0, "R1");
    for (int i = 0; i < 300; i++)
      cyc(1'($urandom), 1'($urandom), 16'($urandom), 1'($urandom), 1'($urandom), "R6");
    // also with B/D set but compatible? A=0,B=0,C=1,D=1 -> legal, no rule checks
    restart(0, 0, 1, 1);
    for (int i = 0; i < 200; i++)
      cyc(1'($urandom), 1'($urandom), 16'($urandom), 1'($urandom), 1'($urandom), "R6");

    // strict, compatible config
    restart(1, 1, 1, 1);
    cyc(0, 1, 16'h1111, 0, 0, "R5");
    cyc(0, 0, 16'h2222, 1, 0, "R5");
    cyc(0, 1, 16'h3333, 0, 1, "R5");
    cyc(1, 0, 16'hAAAA, 1, 0, "R2");
    cyc(1, 0, 16'hAAAA, 1, 0, "R2");
    cyc(1, 1, 16'hAAAA, 1, 0, "R2");
    cyc(1, 1, 16'hBBBB, 0, 1, "R2");
    cyc(0, 0, 16'hCCCC, 0, 0, "R2");
    cyc(1, 1, 16'h1234, 0, 0, "R2");
    cyc(1, 0, 16'h9999, 1, 1, "R2");
    cyc(1, 1, 16'h9999, 1, 1, "R2");
    for (int i = 0; i < 100; i++) begin
      // legal random producer: hold while pending
      bit vi = (m_pend) ? 1'b1 : 1'($urandom);
      logic [DW+1:0] p = m_pend ? m_snap : 18'($urandom);
      cyc(vi, 1'($urandom), p[DW-1:0], p[DW+1], p[DW], "R2");
    end
    while (m_pend) cyc(1, 1, m_snap[DW-1:0], m_snap[DW+1], m_snap[DW], "R2");
    // retraction
    cyc(1, 0, 16'h5555, 0, 0, "R3");
    cyc(0, 0, 16'h5555, 0, 0, "R3");
    cyc(0, 1, 16'h0000, 0, 0, "R3");
    // sticky
    for (int i = 0; i < 5; i++) cyc(0, 1, 16'h0, 0, 0, "R8");

    restart(1, 1, 1, 1);
    cyc(1, 0, 16'h00F0, 0, 0, "R4");
    cyc(1, 0, 16'h00F1, 0, 0, "R4");
    cyc(1, 1, 16'h00F1, 0, 0, "R4");
    restart(1, 0, 0, 0);
    cyc(1, 0, 16'h7777, 0, 0, "R4");
    cyc(1, 0, 16'h7777, 1, 0, "R4");
    cyc(1, 1, 16'h7777, 1, 0, "R4");
    restart(1, 0, 1, 0);
    cyc(1, 0, 16'h7777, 0, 0, "R4");
    cyc(1, 0, 16'h7777, 0, 1, "R4");
    cyc(0, 0, 16'h7777, 0, 1, "R3");
    for (int i = 0; i < 4; i++) cyc(0, 0, 16'h0, 0, 0, "R8");

    // configuration sweep
    for (int k = 0; k < 16; k++) begin
      restart(k[3], k[2], k[1], k[0]);
      cyc(0, 0, 16'h0, 0, 0, "R7");
      cyc(0, 1, 16'h0, 0, 0, "R7");
      cyc(1, 1, 16'h0, 0, 0, "R7");
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule